// File: doc/BRIEF.md
# Address Region Access Checker

This block keeps a small table of programmable memory windows and judges every bus access against it. Each window has an inclusive start and end address, an enable, a write-allow attribute, a privileged-only attribute and a two-bit cipher-select field. One cycle after an access is presented, the block reports whether it fell into an enabled window, which window won, and whether the access broke that window's attributes. The cipher datapath and the bus fabric sit outside. The block only supplies the hit, the window index and the error.

A word-addressed configuration port reads and writes the window registers and a few global registers. A violation sets a sticky illegal-access flag and records a two-bit syndrome that gives the privilege and direction of the offending access. A configuration write that is refused sets a second flag. Either flag can raise the interrupt output when its enable bit is set.

Two controls protect the configuration. A privileged-only control refuses unprivileged configuration writes. A global lock, which only a reset can remove, freezes everything except the interrupt-enable and flag-clear registers.

Top module: `region_guard`

## Requirements
- R1: After a synchronous reset the following are all zero: every window register, both flags, the syndrome, the interrupt enables, the lock, the privileged-only control, `hit`, `acc_err` and `irq`.
- R2: Window i is mapped at configuration offset 0x40 + 0x10*i. Word +0x0 holds the attributes (bit0 enable, bit1 write-allow, bit2 privileged-only, bits 5:4 cipher select, other bits read 0). Word +0x4 holds the start address and word +0x8 the end address. All three words read back what was last accepted.
- R3: An access hits a window when that window is enabled and start <= address <= end, both bounds included. When several windows match, the lowest index wins. `hit` and `hit_region` show the result on the cycle after `acc_valid`. With no access or no match, `hit` is 0 and `hit_region` is 0.
- R4: An access is illegal when it hits and either (a) it is a write and the winning window's write-allow bit is clear, or (b) it is unprivileged and the winning window's privileged-only bit is set. `acc_err` reports this on the same cycle as `hit`. An access that misses every window is never illegal.
- R5: An illegal access sets the illegal flag (status word 0x04, bit0). It also loads the syndrome (word 0x10): bit0 is 1 for a privileged access and bit1 is 1 for a write, so 00 is an unprivileged read, 10 an unprivileged write, 01 a privileged read and 11 a privileged write.
- R6: Writing 1 to bit0 or bit1 of the clear word 0x0C clears the illegal flag or the configuration flag respectively. If a new event for a flag arrives in the same cycle as its clear, the flag stays set.
- R7: `irq` is the OR of (illegal flag AND enable word 0x08 bit0) and (configuration flag AND enable bit1).
- R8: Writing 1 to bit0 of the control word 0x00 sets the global lock. Only a reset clears it. While the lock is set, configuration writes to any address other than 0x08 and 0x0C are ignored, and each one sets the configuration flag (status bit1).
- R9: Control word bit1 is the privileged-only control. While it is set, an unprivileged configuration write to any address is ignored and sets the configuration flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_valid | input | 1 | Configuration request strobe |
| cfg_write | input | 1 | 1 = write, 0 = read |
| cfg_priv | input | 1 | Configuration request is privileged |
| cfg_addr | input | CFG_AW | Byte offset of the configuration word |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Read data for a configuration read (same cycle) |
| acc_valid | input | 1 | Bus access to be checked |
| acc_addr | input | ADDR_W | Bus access address |
| acc_write | input | 1 | Bus access is a write |
| acc_priv | input | 1 | Bus access is privileged |
| hit | output | 1 | Access fell into an enabled window |
| hit_region | output | IDX_W | Index of the winning window |
| acc_err | output | 1 | Access violated the winning window's attributes |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach from the ports is a collision between a new event and a clear of the same flag. In the same clock edge, a violating access or a refused configuration write must land together with a write of 1 to the clear register. The bench drives the access port and the configuration port together in one cycle to set this up. It then reads the status word to see which side won. The lock is also tested after the configuration it guards is already live. Once the lock is set, the bench attempts writes that would change an active window and tries to clear the lock. It then shows through the access path and by read-back that neither attempt had any effect, while writes to the interrupt registers still take effect.

// File: rtl/region_guard_pkg.sv
package region_guard_pkg;

    localparam int DATA_W          = 32;
    localparam int OFF_CTRL        = 'h00;
    localparam int OFF_STATUS      = 'h04;
    localparam int OFF_IRQ_EN      = 'h08;
    localparam int OFF_CLEAR       = 'h0C;
    localparam int OFF_SYND        = 'h10;
    localparam int OFF_REGION_BASE = 'h40;
    localparam int REGION_STRIDE_SH = 4;
    localparam int REGION_STRIDE   = 1 << REGION_STRIDE_SH;

    typedef enum logic [1:0] {
        FLD_ATTR  = 2'd0,
        FLD_START = 2'd1,
        FLD_END   = 2'd2,
        FLD_NONE  = 2'd3
    } region_field_e;

    typedef struct packed {
        logic [1:0] cipher;
        logic       priv_only;
        logic       wr_ok;
        logic       en;
    } region_attr_t;

    typedef enum logic [1:0] {
        SYN_UNPRIV_RD = 2'b00,
        SYN_PRIV_RD   = 2'b01,
        SYN_UNPRIV_WR = 2'b10,
        SYN_PRIV_WR   = 2'b11
    } syndrome_e;

    function automatic logic [DATA_W-1:0] attr_to_word(region_attr_t a);
        return {{(DATA_W-6){1'b0}}, a.cipher, 1'b0, a.priv_only, a.wr_ok, a.en};
    endfunction

    function automatic region_attr_t bits_to_attr(logic [4:0] b);
        region_attr_t a;
        a.cipher    = b[4:3];
        a.priv_only = b[2];
        a.wr_ok     = b[1];
        a.en        = b[0];
        return a;
    endfunction

endpackage

// File: rtl/region_bank.sv
module region_bank
    import region_guard_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int NUM_REGIONS = 4,
    localparam int IDX_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_idx,
    input  region_field_e               wr_field,
    input  logic [DATA_W-1:0]           wdata,
    input  logic [IDX_W-1:0]            rd_idx,
    input  region_field_e               rd_field,
    output logic [DATA_W-1:0]           rdata,
    output region_attr_t                attr  [NUM_REGIONS],
    output logic [ADDR_W-1:0]           lo    [NUM_REGIONS],
    output logic [ADDR_W-1:0]           hi    [NUM_REGIONS]
);

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
        region_attr_t      attr_q;
        logic [ADDR_W-1:0] lo_q;
        logic [ADDR_W-1:0] hi_q;
        logic              sel;

        assign sel = wr_en && (wr_idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                attr_q <= '0;
                lo_q   <= '0;
                hi_q   <= '0;
            end else if (sel) begin
                case (wr_field)
                    FLD_ATTR:  attr_q <= bits_to_attr({wdata[5:4], wdata[2:0]});
                    FLD_START: lo_q   <= wdata[ADDR_W-1:0];
                    FLD_END:   hi_q   <= wdata[ADDR_W-1:0];
                    default:   ;
                endcase
            end
        end

        assign attr[g] = attr_q;
        assign lo[g]   = lo_q;
        assign hi[g]   = hi_q;
    end

    always_comb begin
        case (rd_field)
            FLD_ATTR:  rdata = attr_to_word(attr[rd_idx]);
            FLD_START: rdata = DATA_W'(lo[rd_idx]);
            FLD_END:   rdata = DATA_W'(hi[rd_idx]);
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/region_match.sv
module region_match
    import region_guard_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int NUM_REGIONS = 4,
    localparam int IDX_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
    input  logic              addr_in,
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_write,
    input  logic              is_priv,
    input  region_attr_t      attr [NUM_REGIONS],
    input  logic [ADDR_W-1:0] lo   [NUM_REGIONS],
    input  logic [ADDR_W-1:0] hi   [NUM_REGIONS],
    output logic              any_hit,
    output logic [IDX_W-1:0]  win_idx,
    output logic              violation
);

    logic [NUM_REGIONS-1:0] hit_vec;
    region_attr_t           win_attr;

    always_comb begin
        for (int i = 0; i < NUM_REGIONS; i++) begin
            hit_vec[i] = addr_in && attr[i].en && (addr >= lo[i]) && (addr <= hi[i]);
        end
    end

    // Scan from the top so the lowest matching index is the last one kept.
    always_comb begin
        win_idx = '0;
        for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
            if (hit_vec[i]) win_idx = IDX_W'(i);
        end
    end

    assign any_hit   = |hit_vec;
    assign win_attr  = attr[win_idx];
    assign violation = any_hit &&
                       ((is_write && !win_attr.wr_ok) || (!is_priv && win_attr.priv_only));

endmodule

// File: rtl/fault_tracker.sv
module fault_tracker
    import region_guard_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       viol,
    input  logic       viol_write,
    input  logic       viol_priv,
    input  logic       cfg_fault,
    input  logic       clr_wr,
    input  logic       ien_wr,
    input  logic [1:0] wbits,
    output logic [1:0] flags,
    output syndrome_e  synd,
    output logic [1:0] ien,
    output logic       irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
            synd  <= SYN_UNPRIV_RD;
            ien   <= '0;
        end else begin
            if (viol) begin
                flags[0] <= 1'b1;
                synd     <= syndrome_e'({viol_write, viol_priv});
            end else if (clr_wr && wbits[0]) begin
                flags[0] <= 1'b0;
            end

            if (cfg_fault) begin
                flags[1] <= 1'b1;
            end else if (clr_wr && wbits[1]) begin
                flags[1] <= 1'b0;
            end

            if (ien_wr) ien <= wbits;
        end
    end

    assign irq = |(flags & ien);

endmodule

// File: rtl/region_guard.sv
module region_guard
    import region_guard_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int NUM_REGIONS = 4,
    parameter int CFG_AW      = 8,   // must reach OFF_REGION_BASE + NUM_REGIONS*REGION_STRIDE
    localparam int IDX_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_valid,
    input  logic              cfg_write,
    input  logic              cfg_priv,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_write,
    input  logic              acc_priv,
    output logic              hit,
    output logic [IDX_W-1:0]  hit_region,
    output logic              acc_err,
    output logic              irq
);

    localparam logic [CFG_AW-1:0] A_CTRL   = CFG_AW'(OFF_CTRL);
    localparam logic [CFG_AW-1:0] A_STATUS = CFG_AW'(OFF_STATUS);
    localparam logic [CFG_AW-1:0] A_IRQEN  = CFG_AW'(OFF_IRQ_EN);
    localparam logic [CFG_AW-1:0] A_CLEAR  = CFG_AW'(OFF_CLEAR);
    localparam logic [CFG_AW-1:0] A_SYND   = CFG_AW'(OFF_SYND);
    localparam logic [CFG_AW-1:0] A_RBASE  = CFG_AW'(OFF_REGION_BASE);
    localparam logic [CFG_AW-1:0] R_SPAN   = CFG_AW'(NUM_REGIONS * REGION_STRIDE);

    // ---------------- configuration decode and write gate ----------------
    logic              glock;
    logic              priv_only;
    logic [CFG_AW-1:0] roff;
    logic              in_rgn;
    logic [IDX_W-1:0]  ridx;
    region_field_e     rfield;
    logic              wr_req, irq_space, wr_ok, cfg_fault;

    assign roff      = cfg_addr - A_RBASE;
    assign in_rgn    = (cfg_addr >= A_RBASE) && (roff < R_SPAN);
    assign ridx      = roff[REGION_STRIDE_SH +: IDX_W];
    assign rfield    = region_field_e'(roff[3:2]);

    assign wr_req    = cfg_valid && cfg_write;
    assign irq_space = (cfg_addr == A_IRQEN) || (cfg_addr == A_CLEAR);
    assign wr_ok     = wr_req && !(priv_only && !cfg_priv) && (!glock || irq_space);
    assign cfg_fault = wr_req && !wr_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            glock     <= 1'b0;
            priv_only <= 1'b0;
        end else if (wr_ok && cfg_addr == A_CTRL) begin
            glock     <= glock | cfg_wdata[0];
            priv_only <= cfg_wdata[1];
        end
    end

    // ---------------- window table ----------------
    region_attr_t      attr [NUM_REGIONS];
    logic [ADDR_W-1:0] lo   [NUM_REGIONS];
    logic [ADDR_W-1:0] hi   [NUM_REGIONS];
    logic [DATA_W-1:0] bank_rdata;

    region_bank #(.ADDR_W(ADDR_W), .NUM_REGIONS(NUM_REGIONS)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_ok && in_rgn),
        .wr_idx   (ridx),
        .wr_field (rfield),
        .wdata    (cfg_wdata),
        .rd_idx   (ridx),
        .rd_field (rfield),
        .rdata    (bank_rdata),
        .attr     (attr),
        .lo       (lo),
        .hi       (hi)
    );

    // ---------------- access check ----------------
    logic             any_hit, violation;
    logic [IDX_W-1:0] win_idx;

    region_match #(.ADDR_W(ADDR_W), .NUM_REGIONS(NUM_REGIONS)) u_match (
        .addr_in   (acc_valid),
        .addr      (acc_addr),
        .is_write  (acc_write),
        .is_priv   (acc_priv),
        .attr      (attr),
        .lo        (lo),
        .hi        (hi),
        .any_hit   (any_hit),
        .win_idx   (win_idx),
        .violation (violation)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hit        <= 1'b0;
            hit_region <= '0;
            acc_err    <= 1'b0;
        end else begin
            hit        <= any_hit;
            hit_region <= any_hit ? win_idx : '0;
            acc_err    <= violation;
        end
    end

    // ---------------- flags, syndrome, interrupt ----------------
    logic [1:0] flags;
    logic [1:0] ien;
    syndrome_e  synd;

    fault_tracker u_fault (
        .clk        (clk),
        .rst        (rst),
        .viol       (violation),
        .viol_write (acc_write),
        .viol_priv  (acc_priv),
        .cfg_fault  (cfg_fault),
        .clr_wr     (wr_ok && cfg_addr == A_CLEAR),
        .ien_wr     (wr_ok && cfg_addr == A_IRQEN),
        .wbits      (cfg_wdata[1:0]),
        .flags      (flags),
        .synd       (synd),
        .ien        (ien),
        .irq        (irq)
    );

    // ---------------- read mux ----------------
    always_comb begin
        cfg_rdata = '0;
        if (cfg_valid && !cfg_write) begin
            if (in_rgn)                    cfg_rdata = bank_rdata;
            else if (cfg_addr == A_CTRL)   cfg_rdata = DATA_W'({priv_only, glock});
            else if (cfg_addr == A_STATUS) cfg_rdata = DATA_W'(flags);
            else if (cfg_addr == A_IRQEN)  cfg_rdata = DATA_W'(ien);
            else if (cfg_addr == A_SYND)   cfg_rdata = DATA_W'(synd);
        end
    end

endmodule

// File: rtl/region_guard_chk.sv
module region_guard_chk (
    input logic       clk,
    input logic       rst,
    input logic       acc_valid,
    input logic       hit,
    input logic       acc_err,
    input logic       irq,
    input logic       glock,
    input logic [1:0] flags
);

    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!hit && !acc_err && !irq));

    a_r3_no_access_no_hit: assert property (@(posedge clk) disable iff (rst)
        !$past(acc_valid) |-> !hit);

    a_r4_err_needs_hit: assert property (@(posedge clk) disable iff (rst)
        acc_err |-> hit);

    a_r5_err_sets_flag: assert property (@(posedge clk) disable iff (rst)
        acc_err |-> flags[0]);

    a_r7_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
        irq |-> (flags != 2'b00));

    a_r8_lock_sticky: assert property (@(posedge clk) disable iff (rst)
        $past(glock) |-> glock);

endmodule

bind region_guard region_guard_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .acc_valid (acc_valid),
    .hit       (hit),
    .acc_err   (acc_err),
    .irq       (irq),
    .glock     (glock),
    .flags     (flags)
);

// File: tb/tb_region_guard.sv
`timescale 1ns/1ps
module tb_region_guard;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_valid = 0, cfg_write = 0, cfg_priv = 0;
    logic [7:0]  cfg_addr = 0;
    logic [31:0] cfg_wdata = 0;
    logic [31:0] cfg_rdata;
    logic        acc_valid = 0, acc_write = 0, acc_priv = 0;
    logic [31:0] acc_addr = 0;
    logic        hit, acc_err, irq;
    logic [1:0]  hit_region;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    region_guard dut (
        .clk(clk), .rst(rst),
        .cfg_valid(cfg_valid), .cfg_write(cfg_write), .cfg_priv(cfg_priv),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_write(acc_write), .acc_priv(acc_priv),
        .hit(hit), .hit_region(hit_region), .acc_err(acc_err), .irq(irq)
    );

    // ---------------- behavioural reference model ----------------
    logic [5:0]  m_attr [4];
    logic [31:0] m_lo [4];
    logic [31:0] m_hi [4];
    bit m_lock, m_po, m_fill, m_fcfg;
    bit [1:0] m_ien, m_syn;
    bit e_hit, e_err;
    int e_idx;
    bit h, v, wr, ok, flt;
    int w, ri;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 4; i++) begin m_attr[i] = 0; m_lo[i] = 0; m_hi[i] = 0; end
            m_lock = 0; m_po = 0; m_fill = 0; m_fcfg = 0; m_ien = 0; m_syn = 0;
            e_hit = 0; e_err = 0; e_idx = 0;
        end else begin
            h = 0; v = 0; w = 0;
            if (acc_valid)
                for (int i = 3; i >= 0; i--)
                    if (m_attr[i][0] && acc_addr >= m_lo[i] && acc_addr <= m_hi[i]) begin h = 1; w = i; end
            if (h) v = (acc_write && !m_attr[w][1]) || (!acc_priv && m_attr[w][2]);
            e_hit = h; e_idx = w; e_err = v;

            wr  = cfg_valid && cfg_write;
            ok  = wr && !(m_po && !cfg_priv) &&
                  (!m_lock || cfg_addr == 8'h08 || cfg_addr == 8'h0C);
            flt = wr && !ok;

            if (v) begin m_fill = 1; m_syn = {acc_write, acc_priv}; end
            else if (ok && cfg_addr == 8'h0C && cfg_wdata[0]) m_fill = 0;
            if (flt) m_fcfg = 1;
            else if (ok && cfg_addr == 8'h0C && cfg_wdata[1]) m_fcfg = 0;

            if (ok) begin
                if (cfg_addr == 8'h00) begin m_lock = m_lock | cfg_wdata[0]; m_po = cfg_wdata[1]; end
                else if (cfg_addr == 8'h08) m_ien = cfg_wdata[1:0];
                else if (cfg_addr >= 8'h40 && cfg_addr < 8'h80) begin
                    ri = (cfg_addr - 8'h40) >> 4;
                    case (cfg_addr[3:2])
                        2'd0: m_attr[ri] = {cfg_wdata[5:4], 1'b0, cfg_wdata[2:0]};
                        2'd1: m_lo[ri] = cfg_wdata;
                        2'd2: m_hi[ri] = cfg_wdata;
                        default: ;
                    endcase
                end
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            checks += 3;
            if (hit !== e_hit || (e_hit && hit_region !== 2'(e_idx))) begin
                errors++;
                $display("FAIL R3 cycle hit/idx actual=%0b/%0d expected=%0b/%0d", hit, hit_region, e_hit, e_idx);
            end
            if (acc_err !== e_err) begin
                errors++;
                $display("FAIL R4 cycle acc_err actual=%0b expected=%0b", acc_err, e_err);
            end
            if (irq !== |({m_fcfg, m_fill} & m_ien)) begin
                errors++;
                $display("FAIL R7 cycle irq actual=%0b expected=%0b", irq, |({m_fcfg, m_fill} & m_ien));
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic cfg_wr(input logic [7:0] a, input logic [31:0] d, input bit p);
        @(negedge clk); #1;
        cfg_valid = 1; cfg_write = 1; cfg_priv = p; cfg_addr = a; cfg_wdata = d;
        @(negedge clk); #1;
        cfg_valid = 0; cfg_write = 0;
    endtask

    task automatic cfg_rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk); #1;
        cfg_valid = 1; cfg_write = 0; cfg_addr = a;
        #1 chk(tag, cfg_rdata, exp);
        cfg_valid = 0;
    endtask

    task automatic access(input logic [31:0] a, input bit wrt, input bit p,
                          input bit eh, input logic [1:0] ei, input bit ee, input string tag);
        @(negedge clk); #1;
        acc_valid = 1; acc_addr = a; acc_write = wrt; acc_priv = p;
        @(negedge clk);
        chk(tag, {29'b0, hit, eh ? hit_region : 2'b00, acc_err}, {29'b0, eh, ei, ee});
        #1 acc_valid = 0;
    endtask

    task automatic clear_with_violation(input logic [31:0] a);
        @(negedge clk); #1;
        cfg_valid = 1; cfg_write = 1; cfg_priv = 1; cfg_addr = 8'h0C; cfg_wdata = 32'h1;
        acc_valid = 1; acc_addr = a; acc_write = 0; acc_priv = 0;
        @(negedge clk); #1;
        cfg_valid = 0; cfg_write = 0; acc_valid = 0;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // ---------------- test sequence ----------------
    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); #1 rst = 0;

        // R1 reset state
        cfg_rd(8'h00, 0, "R1 ctrl");
        cfg_rd(8'h04, 0, "R1 status");
        cfg_rd(8'h40, 0, "R1 region0 attr");
        chk("R1 irq", {31'b0, irq}, 0);

        // R2 program windows
        cfg_wr(8'h40, 32'h3, 0);      cfg_wr(8'h44, 32'h1000, 0); cfg_wr(8'h48, 32'h1FFF, 0);
        cfg_wr(8'h50, 32'hFFFF_FF25, 0); cfg_wr(8'h54, 32'h1800, 0); cfg_wr(8'h58, 32'h2FFF, 0);
        cfg_wr(8'h60, 32'h3, 0);      cfg_wr(8'h64, 32'h3000, 0); cfg_wr(8'h68, 32'h3000, 0);
        cfg_wr(8'h70, 32'h2, 0);      cfg_wr(8'h74, 32'h4000, 0); cfg_wr(8'h78, 32'h4FFF, 0);
        cfg_rd(8'h50, 32'h25, "R2 region1 attr masked");
        cfg_rd(8'h54, 32'h1800, "R2 region1 start");
        cfg_rd(8'h68, 32'h3000, "R2 region2 end");

        // R3 matching
        access(32'h1000, 0, 0, 1, 2'd0, 0, "R3 start bound");
        access(32'h1FFF, 0, 0, 1, 2'd0, 0, "R3 end bound and overlap lowest wins");
        access(32'h0FFF, 0, 0, 0, 2'd0, 0, "R3 below start");
        access(32'h3000, 1, 0, 1, 2'd2, 0, "R3 single-address window");
        access(32'h4000, 0, 0, 0, 2'd0, 0, "R3 disabled window");
        access(32'h3001, 1, 0, 0, 2'd0, 0, "R4 miss is never illegal");

        // R4 / R5 violations and syndrome
        access(32'h2000, 0, 0, 1, 2'd1, 1, "R4 unprivileged to privileged-only");
        cfg_rd(8'h04, 32'h1, "R5 illegal flag");
        cfg_rd(8'h10, 32'h0, "R5 syndrome unpriv read");
        access(32'h2000, 1, 1, 1, 2'd1, 1, "R4 write without write-allow");
        cfg_rd(8'h10, 32'h3, "R5 syndrome priv write");
        access(32'h2000, 1, 0, 1, 2'd1, 1, "R4 unpriv write");
        cfg_rd(8'h10, 32'h2, "R5 syndrome unpriv write");
        access(32'h2000, 0, 1, 1, 2'd1, 0, "R4 privileged read allowed");

        // R7 interrupt gating, R6 clear
        chk("R7 irq masked", {31'b0, irq}, 0);
        cfg_wr(8'h08, 32'h1, 0);
        chk("R7 irq enabled", {31'b0, irq}, 1);
        cfg_wr(8'h0C, 32'h1, 0);
        cfg_rd(8'h04, 32'h0, "R6 clear illegal flag");
        chk("R7 irq after clear", {31'b0, irq}, 0);
        clear_with_violation(32'h2000);
        cfg_rd(8'h04, 32'h1, "R6 set wins over clear");
        cfg_wr(8'h0C, 32'h1, 0);

        // R9 privileged-only configuration
        cfg_wr(8'h00, 32'h2, 1);
        cfg_wr(8'h44, 32'h0, 0);
        cfg_rd(8'h44, 32'h1000, "R9 unprivileged write ignored");
        cfg_rd(8'h04, 32'h2, "R9 config flag set");
        cfg_wr(8'h08, 32'h3, 1);
        chk("R7 irq from config flag", {31'b0, irq}, 1);
        cfg_wr(8'h0C, 32'h2, 1);
        cfg_rd(8'h04, 32'h0, "R6 clear config flag");

        // R8 global lock
        cfg_wr(8'h00, 32'h3, 1);
        cfg_wr(8'h40, 32'h0, 1);
        access(32'h1000, 0, 0, 1, 2'd0, 0, "R8 window kept under lock");
        cfg_rd(8'h04, 32'h2, "R8 config flag on locked write");
        cfg_wr(8'h00, 32'h0, 1);
        cfg_rd(8'h00, 32'h3, "R8 lock sticky");
        cfg_wr(8'h08, 32'h0, 1);
        cfg_rd(8'h08, 32'h0, "R8 irq enable writable under lock");
        cfg_wr(8'h0C, 32'h2, 1);
        cfg_rd(8'h04, 32'h0, "R8 clear writable under lock");

        // R1 reset removes the lock
        @(negedge clk); #1 rst = 1;
        repeat (2) @(negedge clk); #1 rst = 0;
        cfg_rd(8'h00, 32'h0, "R1 lock cleared by reset");
        cfg_rd(8'h40, 32'h0, "R1 window cleared by reset");

        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule